// File: doc/BRIEF.md
# Two-Phase Reference Generator with Range Prescaler

This block derives the two square-wave references that drive a phase-locked capacitance-measuring loop from one master clock. A three-stage twisted-ring counter divides its step rate by six. Two of its stages are brought out directly: a reference wave and a copy of it delayed by exactly one step out of six, which is a 60-degree lag. The loop compares the delayed copy against the reference after it has passed through an external RC network.

A range select sets the step rate. In the low range the ring steps on every clock. In the high range a divide-by-1000 prescaler gates the ring, so both references run a thousand times slower. The prescaler counts all the time, and a new range value is only taken at its terminal count. A separate divide-by-three path counts rising edges of the loop oscillator, which runs at six times the reference rate, and forms the measurement output.

Top module: `twophase_refgen`

## Requirements
- R1: While reset is held, and on the first clock after its release, ref_out and lag_out are low and meas_out is high. The low range is in effect after reset.
- R2: In the low range the ring steps on every clock. ref_out is high for three steps and low for three steps, with a period of six clocks. After reset its first high phase starts on the first step.
- R3: lag_out always equals ref_out delayed by exactly one ring step (60 degrees), in both ranges.
- R4: If the ring holds one of the two states outside its six-state cycle (binary 010 or 101), the next step brings it into the cycle. After that, ref_out has exactly two edges in every six steps.
- R5: In the high range the ring steps once every 1000 clocks, so ref_out changes level every 3000 clocks.
- R6: The prescaler wraps every 1000 clocks from reset, whatever the range. The value on range_hi is latched only on the clock where the prescaler count is 999. Until then the previous range stays in force.
- R7: meas_out divides the rising edges of osc_in by three. After k rising edges since reset, meas_out is low when k mod 3 equals 2 and high otherwise. osc_in passes through a two-stage synchronizer, so meas_out reflects an edge three clocks after osc_in rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| range_hi | input | 1 | 1 selects the slow (divide-by-1000) range |
| osc_in | input | 1 | Loop oscillator, asynchronous to clk |
| ref_out | output | 1 | Reference square wave, registered |
| lag_out | output | 1 | Reference delayed by one step of six, registered |
| meas_out | output | 1 | Oscillator divided by three, registered |

## Verification
A ring stuck outside its legal cycle shows at the ports as a 010/101 toggle: ref_out changes on every step instead of every third step. The check that counts edges over six steps catches this within one reference period. A prescaler count that is off, or a range latched at the wrong time, shifts the step timing. In the low range this is visible on the next clock. In the high range it is only visible at the next prescaler wrap, up to 1000 clocks later. A slip in the divide-by-three counter changes the high/low pattern of meas_out within three oscillator edges.

// File: rtl/refgen_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the two-phase reference generator.
// Assumes a three-stage ring; the legal set is the six-state twisted-ring cycle.
package refgen_pkg;
    localparam int RING_W = 3;
    typedef logic [RING_W-1:0] ring_t;

    // True for the two states outside the twisted-ring cycle.
    function automatic logic ring_illegal(input ring_t s);
        return (s == 3'b010) || (s == 3'b101);
    endfunction
endpackage

// File: rtl/range_prescaler.sv
`timescale 1ns/1ps
// Module: range_prescaler
// Free-running terminal-count counter. It emits a step enable for the ring:
// on every clock in the low range, and one clock in PRE_DIV in the high range.
// The range request is latched only at terminal count, so a step is never cut short.
// Assumes PRE_DIV >= 2.
module range_prescaler #(
    parameter int PRE_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic range_req,
    output logic step_en
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] cnt_q;
    logic          range_q;
    logic          tick;

    assign tick = (cnt_q == LAST);

    // Count 0..PRE_DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Latch the range request only at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)    range_q <= 1'b0;
        else if (tick) range_q <= range_req;
    end

    assign step_en = range_q ? tick : 1'b1;

    // R6
    range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(range_q));
    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/johnson_div6.sv
`timescale 1ns/1ps
// Module: johnson_div6
// Three-stage twisted-ring counter, divide by six, advanced by step_en.
// The inverted last stage feeds the first. In the two illegal states the
// feedback is not inverted, which lands the ring on a legal state in one step.
// Tap 2 is the reference and tap 1 is the 60-degree lagging copy.
module johnson_div6
    import refgen_pkg::*;
#(
    parameter ring_t RING_INIT = 3'b000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    output logic ref_out,
    output logic lag_out
);
    ring_t ring_q;
    logic  fb;

    // Feedback: inverted last stage, not inverted when the state is illegal.
    always_comb fb = ring_illegal(ring_q) ? ring_q[0] : ~ring_q[0];

    // Shift toward stage 0 on each enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n)       ring_q <= RING_INIT;
        else if (step_en) ring_q <= {fb, ring_q[2:1]};
    end

    assign ref_out = ring_q[2];
    assign lag_out = ring_q[1];

    // R4
    ring_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ring_illegal(ring_q)) |=> !ring_illegal(ring_q));
    // R3
    lag_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ring_illegal(ring_q)) |=> (lag_out == $past(ref_out)));
    // R5
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(ring_q));
endmodule

// File: rtl/meas_divider.sv
`timescale 1ns/1ps
// Module: meas_divider
// Synchronizes the loop oscillator and divides its rising edges by OUT_DIV.
// The output is high for counts 0..OUT_DIV-2 and low for the last count, and is registered.
// Assumes the oscillator stays high and low for at least two clk periods each.
module meas_divider #(
    parameter int OUT_DIV     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic meas_out
);
    localparam int CW = (OUT_DIV > 1) ? $clog2(OUT_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(OUT_DIV - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic [CW-1:0]          cnt_q;
    logic [CW-1:0]          cnt_nxt;
    logic                   meas_q;

    // Synchronizer chain, plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], osc_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // Next count on a rising edge.
    always_comb cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

    // Edge counter and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            meas_q <= 1'b1;
        end else if (rise) begin
            cnt_q  <= cnt_nxt;
            meas_q <= (cnt_nxt != LAST);
        end
    end

    assign meas_out = meas_q;

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R7
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> ($stable(cnt_q) && $stable(meas_out)));
endmodule

// File: rtl/twophase_refgen.sv
`timescale 1ns/1ps
// Module: twophase_refgen (top)
// Ties together the range prescaler, the twisted-ring divide-by-six and the
// oscillator divide-by-three. All outputs come straight from flops.
// Assumes one clock domain. osc_in is treated as asynchronous.
module twophase_refgen
    import refgen_pkg::*;
#(
    parameter int    PRE_DIV     = 1000,
    parameter int    OUT_DIV     = 3,
    parameter int    SYNC_STAGES = 2,
    parameter ring_t RING_INIT   = 3'b000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic range_hi,
    input  logic osc_in,
    output logic ref_out,
    output logic lag_out,
    output logic meas_out
);
    logic step_en;

    range_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .range_req(range_hi), .step_en(step_en)
    );

    johnson_div6 #(.RING_INIT(RING_INIT)) u_ring (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .ref_out(ref_out), .lag_out(lag_out)
    );

    meas_divider #(.OUT_DIV(OUT_DIV), .SYNC_STAGES(SYNC_STAGES)) u_meas (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .meas_out(meas_out)
    );
endmodule

// File: tb/sim_twophase_refgen.sv
`timescale 1ns/1ps
// Directed bench: a cycle model built from the requirements, one task per scenario.
module sim_twophase_refgen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic range_hi = 1'b0;
    logic osc_in = 1'b0;
    logic ref0, lag0, meas0, ref1, lag1, meas1;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    twophase_refgen u0 (.clk(clk), .rst_n(rst_n), .range_hi(range_hi), .osc_in(osc_in),
                        .ref_out(ref0), .lag_out(lag0), .meas_out(meas0));
    twophase_refgen #(.RING_INIT(3'b010)) u1 (.clk(clk), .rst_n(rst_n), .range_hi(range_hi),
                        .osc_in(osc_in), .ref_out(ref1), .lag_out(lag1), .meas_out(meas1));

    // Model from the requirements: step phase 0..5, prescaler count, latched range.
    int m_cnt = 0;
    int m_ph = 0;
    bit m_rng = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_ph <= 0; m_rng <= 1'b0;
        end else begin
            if (!m_rng || m_cnt == 999) m_ph <= (m_ph + 1) % 6;
            if (m_cnt == 999) begin
                m_cnt <= 0; m_rng <= range_hi;
            end else m_cnt <= m_cnt + 1;
        end
    end

    function automatic bit exp_ref(int ph); return (ph >= 1 && ph <= 3); endfunction
    function automatic bit exp_lag(int ph); return (ph >= 2 && ph <= 4); endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; range_hi = 1'b0; osc_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Compare u0 with the model for n cycles.
    task automatic run_cmp(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ref0 == exp_ref(m_ph), req, ref0, exp_ref(m_ph));
            chk(lag0 == exp_lag(m_ph), "R3", lag0, exp_lag(m_ph));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(ref0 == 1'b0, "R1", ref0, 0);
        chk(lag0 == 1'b0, "R1", lag0, 0);
        chk(meas0 == 1'b1, "R1", meas0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ref0 == 1'b1, "R2", ref0, 1); // first step enters the high phase
    endtask

    task automatic t_low_range();
        int edges = 0;
        bit last;
        do_reset();
        last = ref0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ref0 != last) edges++;
            last = ref0;
        end
        chk(edges == 20, "R2", edges, 20);
        run_cmp(40, "R2");
    endtask

    task automatic t_recovery();
        int edges = 0;
        bit last_r;
        do_reset();
        repeat (2) @(negedge clk);
        last_r = ref1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ref1 != last_r) edges++;
            chk(lag1 == last_r, "R4", lag1, last_r);
            last_r = ref1;
        end
        chk(edges == 2, "R4", edges, 2);
    endtask

    task automatic t_range_switch();
        int edges = 0;
        bit last;
        do_reset();
        repeat (300) @(negedge clk);
        range_hi = 1'b1;
        last = ref0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (ref0 != last) edges++;
            last = ref0;
        end
        chk(edges == 200, "R6", edges, 200); // old range kept until terminal count
        run_cmp(1500, "R6");
    endtask

    task automatic t_high_range();
        int gap = 0;
        bit last;
        // Continues from t_range_switch with the high range active.
        last = ref0;
        while (ref0 == last) @(negedge clk);
        last = ref0;
        while (ref0 == last) begin @(negedge clk); gap++; end
        chk(gap == 3000, "R5", gap, 3000);
        run_cmp(7000, "R5");
        range_hi = 1'b0;
        run_cmp(2500, "R6");
    endtask

    task automatic t_meas();
        do_reset();
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk); osc_in = 1'b1;
            repeat (4) @(negedge clk);
            chk(meas0 == ((k % 3) != 2), "R7", meas0, (k % 3) != 2);
            osc_in = 1'b0;
            repeat (4) @(negedge clk);
            chk(meas0 == ((k % 3) != 2), "R7", meas0, (k % 3) != 2);
        end
        // Latency: the third clock after the rise updates the output.
        @(negedge clk); osc_in = 1'b1; // k = 9 -> high expected; k = 8 was low
        repeat (2) @(negedge clk);
        chk(meas0 == 1'b0, "R7", meas0, 0);
        @(negedge clk);
        chk(meas0 == 1'b1, "R7", meas0, 1);
        osc_in = 1'b0;
    endtask

    bit done = 1'b0;
    initial begin
        t_reset();
        t_low_range();
        t_recovery();
        t_range_switch();
        t_high_range();
        t_meas();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule